// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the byte address of a memory load or store from a base pointer and a displacement, and at the same time produces the value that the base pointer register should hold afterwards. The displacement is given as a count of elements of the access size: bytes, half words, words or double words. The block scales it to bytes before use. The displacement comes from a register, from a 5-bit unsigned immediate or from an implied count of one element.

Seven addressing modes are supported. Plain indirect uses the pointer as is. The two offset modes add or subtract the displacement for this access only. The two pre-modify modes move the pointer first and address with the moved value. The two post-modify modes address with the old pointer and then move it. The block also flags an address that is not a multiple of the access size.

A request is taken on a cycle where `req_vld` is high. The results appear on the registered outputs on the following cycle. The register file, memory access and data formatting sit outside the block.

Top module: `lsagu_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `out_vld`, `out_ptr_we` and `out_misalign` are 0, and `out_addr` and `out_ptr` are 0.
- R2: A request on a cycle with `req_vld` high produces `out_vld` high on exactly the next cycle. After a cycle without a request, `out_vld` and `out_ptr_we` are 0, and `out_addr`, `out_ptr` and `out_misalign` keep their previous values.
- R3: Mode code 0 (indirect): the address equals the base, `out_ptr` equals the base, and `out_ptr_we` is 0.
- R4: Mode codes 1 (offset add) and 2 (offset subtract): the address is the base plus or minus the scaled displacement, `out_ptr` equals the base, and `out_ptr_we` is 0.
- R5: Mode codes 3 (pre-increment) and 4 (pre-decrement): the address and `out_ptr` both equal the base plus or minus the scaled displacement, and `out_ptr_we` is 1.
- R6: Mode codes 5 (post-increment) and 6 (post-decrement): the address equals the old base, `out_ptr` is the base plus or minus the scaled displacement, and `out_ptr_we` is 1.
- R7: The scaled displacement is the element count shifted left by the size code. Size codes are 0 byte, 1 half word, 2 word and 3 double word.
- R8: Displacement source code 0 takes `req_dreg`. Code 1 takes `req_dimm`, zero-extended. Code 2 takes a count of one element. Code 3 takes a count of zero.
- R9: `out_misalign` is 1 when the address is not a multiple of the access size in bytes (1, 2, 4 or 8), otherwise 0.
- R10: All additions, subtractions and scaling wrap modulo 2^32.
- R11: Mode code 7 behaves like indirect: the address and `out_ptr` equal the base, and `out_ptr_we` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Access size code |
| req_base | input | 32 | Base pointer value |
| req_dsrc | input | 2 | Displacement source select |
| req_dreg | input | 32 | Displacement count from a register |
| req_dimm | input | 5 | Unsigned immediate displacement count |
| out_vld | output | 1 | Result valid |
| out_addr | output | 32 | Effective byte address |
| out_ptr | output | 32 | Value for the base pointer register |
| out_ptr_we | output | 1 | Base pointer write enable |
| out_misalign | output | 1 | Address not aligned to the access size |

## Verification
Directed requests apply every mode to the same base and displacement. A sum and a difference of equal magnitude give different addresses and different pointer values, so these requests show which operand feeds the address and which feeds the write-back in each mode. Further patterns give each size a nonzero count and use every displacement source, which exposes a wrong shift or a wrong source. Requests that straddle zero and the top of the address space catch arithmetic that does not wrap, and bases ending in 1, 2, 4 and 6 show which sizes count as misaligned. A long random stream with idle gaps checks that the outputs hold between requests.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    AM_IND   = 3'd0,
    AM_OFSADD = 3'd1,
    AM_OFSSUB = 3'd2,
    AM_PREINC = 3'd3,
    AM_PREDEC = 3'd4,
    AM_PSTINC = 3'd5,
    AM_PSTDEC = 3'd6,
    AM_RSVD   = 3'd7
  } addr_mode_e;

  typedef enum logic [1:0] {
    DS_REG  = 2'd0,
    DS_IMM  = 2'd1,
    DS_ONE  = 2'd2,
    DS_NONE = 2'd3
  } disp_src_e;

  localparam int unsigned NUM_SIZES = 4;

endpackage

// File: rtl/lsagu_disp.sv
module lsagu_disp
  import lsagu_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 5
) (
  input  disp_src_e        src,
  input  acc_size_e        size,
  input  logic [AW-1:0]    dreg,
  input  logic [IMM_W-1:0] dimm,
  output logic [AW-1:0]    scaled
);

  logic [AW-1:0] count;
  logic [AW-1:0] cand [NUM_SIZES];

  always_comb begin
    unique case (src)
      DS_REG:  count = dreg;
      DS_IMM:  count = {{(AW-IMM_W){1'b0}}, dimm};
      DS_ONE:  count = AW'(1);
      default: count = '0;
    endcase
  end

  // one shifted candidate per access size; wraps by truncation
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_shift
    assign cand[g] = count << g;
  end

  assign scaled = cand[size];

endmodule

// File: rtl/lsagu_arith.sv
module lsagu_arith #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] scaled,
  output logic [AW-1:0] sum,
  output logic [AW-1:0] diff
);

  assign sum  = base + scaled;
  assign diff = base - scaled;

endmodule

// File: rtl/lsagu_select.sv
module lsagu_select
  import lsagu_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  addr_mode_e    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] sum,
  input  logic [AW-1:0] diff,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] ptr,
  output logic          ptr_we
);

  always_comb begin
    addr   = base;
    ptr    = base;
    ptr_we = 1'b0;
    unique case (mode)
      AM_OFSADD: addr = sum;
      AM_OFSSUB: addr = diff;
      AM_PREINC: begin addr = sum;  ptr = sum;  ptr_we = 1'b1; end
      AM_PREDEC: begin addr = diff; ptr = diff; ptr_we = 1'b1; end
      AM_PSTINC: begin ptr = sum;  ptr_we = 1'b1; end
      AM_PSTDEC: begin ptr = diff; ptr_we = 1'b1; end
      default: begin
        addr   = base;
        ptr    = base;
        ptr_we = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lsagu_align.sv
module lsagu_align
  import lsagu_pkg::*;
(
  input  acc_size_e  size,
  input  logic [2:0] addr_lo,
  output logic       misalign
);

  logic [2:0] mask;

  always_comb begin
    unique case (size)
      SZ_BYTE: mask = 3'b000;
      SZ_HALF: mask = 3'b001;
      SZ_WORD: mask = 3'b011;
      default: mask = 3'b111;
    endcase
  end

  assign misalign = |(addr_lo & mask);

endmodule

// File: rtl/lsagu_top.sv
module lsagu_top
  import lsagu_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_vld,
  input  logic [2:0]       req_mode,
  input  logic [1:0]       req_size,
  input  logic [AW-1:0]    req_base,
  input  logic [1:0]       req_dsrc,
  input  logic [AW-1:0]    req_dreg,
  input  logic [IMM_W-1:0] req_dimm,
  output logic             out_vld,
  output logic [AW-1:0]    out_addr,
  output logic [AW-1:0]    out_ptr,
  output logic             out_ptr_we,
  output logic             out_misalign
);

  // reset: asserted at once, released on the second clock edge
  logic rst_meta_n, rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  acc_size_e  size_c;
  addr_mode_e mode_c;
  disp_src_e  src_c;

  assign size_c = acc_size_e'(req_size);
  assign mode_c = addr_mode_e'(req_mode);
  assign src_c  = disp_src_e'(req_dsrc);

  logic [AW-1:0] scaled, sum, diff, addr_d, ptr_d;
  logic          we_d, mis_d;

  lsagu_disp #(.AW(AW), .IMM_W(IMM_W)) u_disp (
    .src(src_c), .size(size_c), .dreg(req_dreg), .dimm(req_dimm), .scaled(scaled)
  );

  lsagu_arith #(.AW(AW)) u_arith (
    .base(req_base), .scaled(scaled), .sum(sum), .diff(diff)
  );

  lsagu_select #(.AW(AW)) u_sel (
    .mode(mode_c), .base(req_base), .sum(sum), .diff(diff),
    .addr(addr_d), .ptr(ptr_d), .ptr_we(we_d)
  );

  lsagu_align u_align (
    .size(size_c), .addr_lo(addr_d[2:0]), .misalign(mis_d)
  );

  // next-state for the output stage
  logic [AW-1:0] addr_n, ptr_n;
  logic          vld_n, we_n, mis_n;

  always_comb begin
    vld_n  = req_vld;
    we_n   = req_vld & we_d;
    addr_n = out_addr;
    ptr_n  = out_ptr;
    mis_n  = out_misalign;
    if (req_vld) begin
      addr_n = addr_d;
      ptr_n  = ptr_d;
      mis_n  = mis_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_vld      <= 1'b0;
      out_ptr_we   <= 1'b0;
      out_addr     <= '0;
      out_ptr      <= '0;
      out_misalign <= 1'b0;
    end else begin
      out_vld      <= vld_n;
      out_ptr_we   <= we_n;
      out_addr     <= addr_n;
      out_ptr      <= ptr_n;
      out_misalign <= mis_n;
    end
  end

endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_vld,
  input logic [2:0]    req_mode,
  input logic [1:0]    req_size,
  input logic [AW-1:0] req_base,
  input logic          out_vld,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_ptr,
  input logic          out_ptr_we,
  input logic          out_misalign
);

  AST_VLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> out_vld) else $error("vld"); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> (!out_vld && !out_ptr_we && $stable(out_addr) && $stable(out_ptr))) else $error("hold"); // R2

  AST_IND_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == 3'd0 || req_mode == 3'd7)) |=>
      (!out_ptr_we && out_addr == $past(req_base) && out_ptr == $past(req_base))) else $error("ind"); // R3

  AST_OFS_KEEP_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == 3'd1 || req_mode == 3'd2)) |=>
      (!out_ptr_we && out_ptr == $past(req_base))) else $error("ofs"); // R4

  AST_PRE_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == 3'd3 || req_mode == 3'd4)) |=>
      (out_ptr_we && out_addr == out_ptr)) else $error("pre"); // R5

  AST_POST_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && (req_mode == 3'd5 || req_mode == 3'd6)) |=>
      (out_ptr_we && out_addr == $past(req_base))) else $error("post"); // R6

  AST_BYTE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && req_size == 2'd0) |=> !out_misalign) else $error("mis"); // R9

  AST_WE_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_ptr_we |-> out_vld) else $error("we"); // R2

endmodule

bind lsagu_top lsagu_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .req_vld(req_vld), .req_mode(req_mode),
  .req_size(req_size), .req_base(req_base), .out_vld(out_vld),
  .out_addr(out_addr), .out_ptr(out_ptr), .out_ptr_we(out_ptr_we),
  .out_misalign(out_misalign)
);

// File: tb/lsagu_top_tb.sv
module lsagu_top_tb;

  localparam int unsigned CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld;
  logic [2:0]  req_mode;
  logic [1:0]  req_size;
  logic [31:0] req_base;
  logic [1:0]  req_dsrc;
  logic [31:0] req_dreg;
  logic [4:0]  req_dimm;
  logic        out_vld, out_ptr_we, out_misalign;
  logic [31:0] out_addr, out_ptr;

  int n_chk = 0;
  int n_bad = 0;

  logic        e_vld = 0, e_we = 0, e_mis = 0;
  logic [31:0] e_addr = 0, e_ptr = 0;
  string       e_tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  lsagu_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
    .req_size(req_size), .req_base(req_base), .req_dsrc(req_dsrc),
    .req_dreg(req_dreg), .req_dimm(req_dimm), .out_vld(out_vld),
    .out_addr(out_addr), .out_ptr(out_ptr), .out_ptr_we(out_ptr_we),
    .out_misalign(out_misalign)
  );

  task automatic cmp(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    cmp("R2", "out_vld", out_vld, e_vld);
    cmp(e_tag, "out_ptr_we", out_ptr_we, e_we);
    cmp(e_tag, "out_addr", out_addr, e_addr);
    cmp(e_tag, "out_ptr", out_ptr, e_ptr);
    cmp("R9", "out_misalign", out_misalign, e_mis);
  endtask

  // behavioural reference for one request
  task automatic model(input logic [2:0] m, input logic [1:0] s, input logic [31:0] b,
                       input logic [1:0] ds, input logic [31:0] dr, input logic [4:0] di,
                       input string extra);
    longint cnt, bytes;
    logic [31:0] sd, up, dn;
    bytes = longint'(1) << s;
    case (ds)
      2'd0: cnt = longint'(dr);
      2'd1: cnt = longint'(di);
      2'd2: cnt = 1;
      default: cnt = 0;
    endcase
    sd = 32'((cnt * bytes) % 64'h1_0000_0000);
    up = 32'((longint'(b) + longint'(sd)) % 64'h1_0000_0000);
    dn = 32'((longint'(b) + 64'h1_0000_0000 - longint'(sd)) % 64'h1_0000_0000);
    e_we = 0; e_addr = b; e_ptr = b;
    case (m)
      3'd0: e_tag = "R3";
      3'd1: begin e_addr = up; e_tag = "R4"; end
      3'd2: begin e_addr = dn; e_tag = "R4"; end
      3'd3: begin e_addr = up; e_ptr = up; e_we = 1; e_tag = "R5"; end
      3'd4: begin e_addr = dn; e_ptr = dn; e_we = 1; e_tag = "R5"; end
      3'd5: begin e_ptr = up; e_we = 1; e_tag = "R6"; end
      3'd6: begin e_ptr = dn; e_we = 1; e_tag = "R6"; end
      default: e_tag = "R11";
    endcase
    if (extra != "") e_tag = {e_tag, "/", extra};
    e_mis = (longint'(e_addr) % bytes) != 0;
  endtask

  task automatic step(input logic v, input logic [2:0] m, input logic [1:0] s,
                      input logic [31:0] b, input logic [1:0] ds, input logic [31:0] dr,
                      input logic [4:0] di, input string extra);
    @(negedge clk);
    check_outputs();
    req_vld = v; req_mode = m; req_size = s; req_base = b;
    req_dsrc = ds; req_dreg = dr; req_dimm = di;
    e_vld = v;
    if (v) model(m, s, b, ds, dr, di, extra);
    else begin e_we = 0; e_tag = "R2"; end
  endtask

  task automatic idle();
    step(1'b0, 3'd0, 2'd0, 32'hDEAD_BEEF, 2'd0, 32'h5, 5'd3, "");
  endtask

  initial begin
    rst_n = 0; req_vld = 0; req_mode = 0; req_size = 0; req_base = 0;
    req_dsrc = 0; req_dreg = 0; req_dimm = 0;
    repeat (3) @(negedge clk);
    cmp("R1", "reset vld", out_vld, 0);
    cmp("R1", "reset addr", out_addr, 0);
    cmp("R1", "reset we", out_ptr_we, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    cmp("R1", "post-reset ptr", out_ptr, 0);
    cmp("R1", "post-reset mis", out_misalign, 0);

    // every mode, same base and displacement: R3 R4 R5 R6
    for (int m = 0; m < 8; m++) step(1, 3'(m), 2'd2, 32'h0000_1000, 2'd0, 32'd5, 5'd0, "modes");
    idle(); idle();
    // R7: size scaling with a register count
    for (int s = 0; s < 4; s++) step(1, 3'd1, 2'(s), 32'h0000_8000, 2'd0, 32'd3, 5'd0, "R7");
    for (int s = 0; s < 4; s++) step(1, 3'd6, 2'(s), 32'h0000_8000, 2'd1, 32'd0, 5'd31, "R7");
    // R8: each displacement source
    step(1, 3'd3, 2'd2, 32'h0000_0100, 2'd0, 32'd7, 5'd2, "R8");
    step(1, 3'd3, 2'd2, 32'h0000_0100, 2'd1, 32'd7, 5'd2, "R8");
    step(1, 3'd3, 2'd2, 32'h0000_0100, 2'd2, 32'd7, 5'd2, "R8");
    step(1, 3'd3, 2'd2, 32'h0000_0100, 2'd3, 32'd7, 5'd2, "R8");
    step(1, 3'd5, 2'd3, 32'h0000_0100, 2'd2, 32'd7, 5'd2, "R8");
    // R10: wrap at both ends
    step(1, 3'd3, 2'd2, 32'hFFFF_FFFC, 2'd2, 32'd0, 5'd0, "R10");
    step(1, 3'd2, 2'd0, 32'h0000_0000, 2'd1, 32'd0, 5'd1, "R10");
    step(1, 3'd5, 2'd3, 32'hFFFF_FFF8, 2'd0, 32'h2000_0001, 5'd0, "R10");
    step(1, 3'd4, 2'd1, 32'h0000_0002, 2'd0, 32'h8000_0003, 5'd0, "R10");
    // R9: alignment per size
    for (int s = 0; s < 4; s++) begin
      step(1, 3'd0, 2'(s), 32'h0000_1001, 2'd0, 32'd0, 5'd0, "R9");
      step(1, 3'd0, 2'(s), 32'h0000_1002, 2'd0, 32'd0, 5'd0, "R9");
      step(1, 3'd0, 2'(s), 32'h0000_1004, 2'd0, 32'd0, 5'd0, "R9");
      step(1, 3'd0, 2'(s), 32'h0000_1006, 2'd0, 32'd0, 5'd0, "R9");
    end
    // R11: reserved mode with a large displacement
    step(1, 3'd7, 2'd3, 32'h0000_4444, 2'd1, 32'd0, 5'd17, "R11");
    idle();
    // random stream with idle gaps (R2 hold)
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom_range(0, 3) != 0), 3'($urandom), 2'($urandom), $urandom,
           2'($urandom), $urandom, 5'($urandom), "rnd");
    end
    idle(); idle();
    @(negedge clk);
    check_outputs();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule